// File: doc/BRIEF.md
# Paired-Register 128-bit Atomic OR Unit

This unit executes one instruction class: an atomic bit-set on a 128-bit quadword. It accepts a 32-bit instruction word, decodes and validates it, and reads three registers through a register-file port: two 64-bit data registers and one base-address register. For base field 31 it uses the stack pointer instead of a register. It then runs one indivisible read-modify-write on a 128-bit memory port. The port is held locked through a read of the quadword and a write of the quadword ORed with the register-pair operand. The original quadword is then written back into the register pair.

The order in which the two registers are packed into the operand and unpacked from the loaded value is chosen by a big-endian mode input. The acquire and release bits of the encoding are presented as ordering flags alongside the memory access. A tag-check flag shows whether the address came from a general register.

Encodings the unit rejects end with a fault indication and no memory traffic:
- a wrong opcode pattern,
- register 31 used as a data register,
- a misaligned stack pointer.

A same-register pair is handled as the parameter `OVERLAP_MODE` selects. Every instruction, accepted or rejected, finishes with a one-cycle completion pulse.

Top module: `quad_or_atomic`

## Requirements
- R1: An instruction word is recognised only when bits 31:24 are 8'b00011001, bit 21 is 1 and bits 15:10 are 6'b001100. Any other word completes with `undef`=1, `wb_en`=0 and no memory request.
- R2: If the first data field (bits 4:0) or the second data field (bits 20:16) equals 31, the instruction completes with `undef`=1, `wb_en`=0 and no memory request.
- R3: When both data fields name the same register, `OVERLAP_MODE` selects the behaviour:
  - 0: the memory access is performed and both write-back values equal `POISON`.
  - 1: the instruction completes with `undef`=1 and no access.
  - 2: the instruction completes with no write-back, no fault and no access.
- R4: Base field (bits 9:5) value 31 selects `sp` as the address. Any nonzero value in `sp[3:0]` then completes with `align_fault`=1 and no access, and `tag_chk` is 0 for stack-pointer accesses. Any other base value uses the register value and drives `tag_chk`=1 during the access. A decode fault takes precedence over the alignment check.
- R5: The operand is {second, first} (second register in bits 127:64) when `big_endian`=0, and {first, second} when `big_endian`=1.
- R6: A memory instruction issues a read with `mem_lock`=1, then a write of (loaded OR operand) to the same address with `mem_lock` still 1. `mem_lock` drops after the write is acknowledged.
- R7: Completion is a one-cycle `done` pulse. When registers are written, `wb_en`=1 in the same cycle, and `wb_a_idx`/`wb_b_idx` equal the first and second data fields.
  - With `big_endian`=0, `wb_a_data` is loaded bits 63:0 and `wb_b_data` is loaded bits 127:64.
  - With `big_endian`=1, the halves are swapped.
- R8: `acq` equals instruction bit 23 and `rel` equals bit 22 during the memory access. Both are 0 outside it.
- R9: `issue_ready` is 1 only while idle. No instruction is accepted from acceptance until the cycle after `done`.
- R10: Latency is independent of data. With `mem_ready` held at 1, a memory instruction raises `done` 3 cycles after the acceptance edge, and a rejected or no-op instruction raises it 1 cycle after, whatever the register and memory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, instruction taken on this edge |
| insn | input | 32 | Instruction word |
| big_endian | input | 1 | Register-pair packing order |
| rf_a_idx | output | 5 | Read index, first data register |
| rf_b_idx | output | 5 | Read index, second data register |
| rf_base_idx | output | 5 | Read index, base register |
| rf_a_data | input | 64 | First data register value |
| rf_b_data | input | 64 | Second data register value |
| rf_base_data | input | 64 | Base register value |
| sp | input | 64 | Stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Atomic lock held |
| mem_addr | output | 64 | Quadword address |
| mem_wdata | output | 128 | Write data |
| mem_ready | input | 1 | Request acknowledged |
| mem_rdata | input | 128 | Read data, valid with read acknowledge |
| acq | output | 1 | Acquire ordering flag |
| rel | output | 1 | Release ordering flag |
| tag_chk | output | 1 | Access is tag-checked |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Register write-back valid |
| wb_a_idx | output | 5 | First write-back register |
| wb_b_idx | output | 5 | Second write-back register |
| wb_a_data | output | 64 | First write-back value |
| wb_b_data | output | 64 | Second write-back value |
| undef | output | 1 | Undefined encoding, with done |
| align_fault | output | 1 | Stack-pointer misalignment, with done |

## Verification
The assertions check the handshake shape on every cycle:
- every request is locked;
- an acknowledged read is followed at once by a locked write;
- write data holds while the write waits;
- `issue_ready` never overlaps a request;
- `done` is a single pulse, and a fault never carries a write-back;
- ordering flags appear only during an access.

Data correctness can only come from the bench's scenarios, against its own memory and register model:
- the OR result left in memory and the endian-dependent packing and unpacking;
- the poison value on overlap;
- fault precedence;
- equal latency for different data.

The bench uses the default overlap mode.

// File: rtl/quad_or_atomic.sv
module quad_or_atomic #(
  parameter int XLEN = 64,
  parameter int ALIGN_BITS = 4,
  parameter int OVERLAP_MODE = 0,
  parameter logic [XLEN-1:0] POISON = {(XLEN/16){16'hBAD5}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       insn,
  input  logic              big_endian,
  output logic [4:0]        rf_a_idx,
  output logic [4:0]        rf_b_idx,
  output logic [4:0]        rf_base_idx,
  input  logic [XLEN-1:0]   rf_a_data,
  input  logic [XLEN-1:0]   rf_b_data,
  input  logic [XLEN-1:0]   rf_base_data,
  input  logic [XLEN-1:0]   sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [XLEN-1:0]   mem_addr,
  output logic [2*XLEN-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [2*XLEN-1:0] mem_rdata,
  output logic              acq,
  output logic              rel,
  output logic              tag_chk,
  output logic              done,
  output logic              wb_en,
  output logic [4:0]        wb_a_idx,
  output logic [4:0]        wb_b_idx,
  output logic [XLEN-1:0]   wb_a_data,
  output logic [XLEN-1:0]   wb_b_data,
  output logic              undef,
  output logic              align_fault
);
  localparam int QW = 2 * XLEN;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_t;
  st_t state;

  logic [XLEN-1:0] addr_q;
  logic [QW-1:0]   opnd_q, old_q;
  logic [4:0]      rt_q, rt2_q;
  logic            be_q, acq_q, rel_q, tag_q, undef_q, afault_q, wb_q, poison_q;

  wire [4:0] f_rt  = insn[4:0];
  wire [4:0] f_rn  = insn[9:5];
  wire [4:0] f_rt2 = insn[20:16];

  assign rf_a_idx    = f_rt;
  assign rf_b_idx    = f_rt2;
  assign rf_base_idx = f_rn;

  wire is_match = (insn[31:24] == 8'b0001_1001) && insn[21] && (insn[15:10] == 6'b001100);
  wire bad_reg  = (f_rt == 5'd31) || (f_rt2 == 5'd31);
  wire overlap  = (f_rt == f_rt2);
  wire use_sp   = (f_rn == 5'd31);
  wire go_undef = !is_match || bad_reg || (overlap && OVERLAP_MODE == 1);
  wire go_nop   = !go_undef && overlap && OVERLAP_MODE == 2;
  wire misal    = !go_undef && !go_nop && use_sp && (|sp[ALIGN_BITS-1:0]);
  wire go_mem   = !go_undef && !go_nop && !misal;

  wire [QW-1:0] operand = big_endian ? {rf_a_data, rf_b_data} : {rf_b_data, rf_a_data};
  wire          accept  = issue_valid && (state == S_IDLE);
  wire          in_acc  = (state == S_RD) || (state == S_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      opnd_q   <= '0;
      old_q    <= '0;
      rt_q     <= '0;
      rt2_q    <= '0;
      be_q     <= 1'b0;
      acq_q    <= 1'b0;
      rel_q    <= 1'b0;
      tag_q    <= 1'b0;
      undef_q  <= 1'b0;
      afault_q <= 1'b0;
      wb_q     <= 1'b0;
      poison_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          addr_q   <= use_sp ? sp : rf_base_data;
          opnd_q   <= operand;
          rt_q     <= f_rt;
          rt2_q    <= f_rt2;
          be_q     <= big_endian;
          acq_q    <= insn[23];
          rel_q    <= insn[22];
          tag_q    <= !use_sp;
          undef_q  <= go_undef;
          afault_q <= misal;
          wb_q     <= go_mem;
          poison_q <= overlap;
          state    <= go_mem ? S_RD : S_FIN;
        end
        S_RD: if (mem_ready) begin
          old_q <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ready) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign issue_ready = (state == S_IDLE);
  assign mem_req     = in_acc;
  assign mem_we      = (state == S_WR);
  assign mem_lock    = in_acc;
  assign mem_addr    = addr_q;
  assign mem_wdata   = old_q | opnd_q;
  assign acq         = in_acc && acq_q;
  assign rel         = in_acc && rel_q;
  assign tag_chk     = in_acc && tag_q;
  assign done        = (state == S_FIN);
  assign wb_en       = done && wb_q;
  assign undef       = done && undef_q;
  assign align_fault = done && afault_q;
  assign wb_a_idx    = rt_q;
  assign wb_b_idx    = rt2_q;
  assign wb_a_data   = poison_q ? POISON : (be_q ? old_q[QW-1:XLEN] : old_q[XLEN-1:0]);
  assign wb_b_data   = poison_q ? POISON : (be_q ? old_q[XLEN-1:0] : old_q[QW-1:XLEN]);

  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);  // R6
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we && mem_lock));  // R6
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata) && $stable(mem_addr));  // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_ready && (mem_req || done)));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);  // R7
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || align_fault) |-> !wb_en);  // R2
  AST_FAULTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef && align_fault));  // R4
  AST_FLAGS_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (acq || rel || tag_chk) |-> mem_req);  // R8
endmodule

// File: tb/quad_or_atomic_tb.sv
`timescale 1ns/1ps
module quad_or_atomic_tb;
  localparam logic [63:0] PZN = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic issue_valid = 0, big_endian = 0, mem_ready = 0;
  logic [31:0] insn = 0;
  logic [63:0] sp_v = 0;
  logic issue_ready, mem_req, mem_we, mem_lock, acq, rel, tag_chk;
  logic done, wb_en, undef, align_fault;
  logic [4:0] rf_a_idx, rf_b_idx, rf_base_idx, wb_a_idx, wb_b_idx;
  logic [63:0] mem_addr, wb_a_data, wb_b_data;
  logic [127:0] mem_wdata, mem_rdata;
  logic [63:0] rf [32];
  logic [127:0] mem [16];

  quad_or_atomic #(.POISON(PZN)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .insn(insn), .big_endian(big_endian),
    .rf_a_idx(rf_a_idx), .rf_b_idx(rf_b_idx), .rf_base_idx(rf_base_idx),
    .rf_a_data(rf[rf_a_idx]), .rf_b_data(rf[rf_b_idx]), .rf_base_data(rf[rf_base_idx]),
    .sp(sp_v), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .acq(acq), .rel(rel), .tag_chk(tag_chk), .done(done), .wb_en(wb_en),
    .wb_a_idx(wb_a_idx), .wb_b_idx(wb_b_idx), .wb_a_data(wb_a_data), .wb_b_data(wb_b_data),
    .undef(undef), .align_fault(align_fault));

  assign mem_rdata = mem[mem_addr[7:4]];

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, lock_bad = 0, last_lat = 0;
  bit rdy_always = 1;
  logic [63:0] seen_addr;
  logic seen_acq, seen_rel, seen_tag;

  always @(negedge clk) mem_ready <= rdy_always ? 1'b1 : 1'($urandom % 2);

  always @(posedge clk) begin
    if (mem_req && !mem_lock) lock_bad <= lock_bad + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        mem[mem_addr[7:4]] <= mem_wdata;
        if (mem_addr != seen_addr) lock_bad <= lock_bad + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
        seen_addr <= mem_addr;
        seen_acq <= acq;
        seen_rel <= rel;
        seen_tag <= tag_chk;
      end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit a, input bit r, input logic [4:0] t2,
                                     input logic [4:0] n, input logic [4:0] t);
    return {8'b0001_1001, a, r, 1'b1, t2, 6'b001100, n, t};
  endfunction

  task automatic do_op(input logic [31:0] ins, input bit be, input string tag);
    logic [4:0] t = ins[4:0], n = ins[9:5], t2 = ins[20:16];
    bit match = (ins[31:24] == 8'b0001_1001) && ins[21] && (ins[15:10] == 6'b001100);
    bit undef_e = !match || t == 31 || t2 == 31;
    bit mis_e = !undef_e && n == 31 && sp_v[3:0] != 0;
    bit mem_e = !undef_e && !mis_e;
    logic [63:0] adr = (n == 31) ? sp_v : rf[n];
    logic [127:0] old = mem[adr[7:4]];
    logic [127:0] opnd = be ? {rf[t], rf[t2]} : {rf[t2], rf[t]};
    logic [63:0] ea = be ? old[127:64] : old[63:0];
    logic [63:0] eb = be ? old[63:0] : old[127:64];
    int cyc;
    if (mem_e && t == t2) begin ea = PZN; eb = PZN; end
    @(negedge clk);
    insn = ins; big_endian = be; issue_valid = 1;
    rd_cnt = 0; wr_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    issue_valid = 0;
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    last_lat = cyc;
    chk({tag, " R7 done"}, done, 1);
    chk({tag, " R1 R2 undef"}, undef, undef_e);
    chk({tag, " R4 align_fault"}, align_fault, mis_e);
    chk({tag, " R7 wb_en"}, wb_en, mem_e);
    chk({tag, " R6 reads"}, rd_cnt, mem_e);
    chk({tag, " R6 writes"}, wr_cnt, mem_e);
    chk({tag, " R6 lock/addr"}, lock_bad, 0);
    chk({tag, " R9 busy"}, issue_ready, 0);
    if (mem_e) begin
      chk({tag, " R4 addr"}, seen_addr, adr);
      chk({tag, " R4 tag_chk"}, seen_tag, n != 31);
      chk({tag, " R8 acq/rel"}, {seen_acq, seen_rel}, ins[23:22]);
      chk({tag, " R5 R6 mem result"}, mem[adr[7:4]], old | opnd);
      chk({tag, " R7 idx"}, {wb_a_idx, wb_b_idx}, {t, t2});
      chk({tag, " R7 R3 wb data"}, {wb_a_data, wb_b_data}, {ea, eb});
      rf[t] = ea;
      rf[t2] = eb;
    end
    @(posedge clk);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #750us;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < 32; i++) rf[i] = r64();
    for (int i = 0; i < 16; i++) mem[i] = {r64(), r64()};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset R9 ready", issue_ready, 1);
    chk("reset R7 done", done, 0);
    chk("reset R6 req", {mem_req, mem_lock}, 0);
    rst_n = 1;

    // R5 R7: known pattern, little and big endian
    rf[1] = 64'h0000_0000_0000_00F0; rf[2] = 64'h0F00_0000_0000_0000; rf[3] = 64'h40;
    mem[4] = {64'hAAAA_0000_0000_0001, 64'h0000_0000_0000_0002};
    do_op(mk(0, 0, 5'd2, 5'd3, 5'd1), 0, "dir le");
    rf[1] = 64'h11; rf[2] = 64'h22; rf[3] = 64'h50;
    do_op(mk(1, 1, 5'd2, 5'd3, 5'd1), 1, "dir be");
    // R1: bad opcode, R2: register 31
    do_op(mk(0, 0, 5'd2, 5'd3, 5'd1) ^ 32'h0000_0400, 0, "R1 opc");
    do_op(mk(0, 0, 5'd2, 5'd3, 5'd1) & ~32'h0020_0000, 0, "R1 bit21");
    do_op(mk(0, 0, 5'd31, 5'd3, 5'd1), 0, "R2 rt2");
    do_op(mk(0, 0, 5'd2, 5'd3, 5'd31), 0, "R2 rt");
    // R3 overlap: poison
    do_op(mk(0, 1, 5'd7, 5'd3, 5'd7), 0, "R3 overlap");
    // R4 stack pointer aligned and misaligned; undef wins over misalign
    sp_v = 64'h1000_0070;
    do_op(mk(1, 0, 5'd2, 5'd31, 5'd1), 0, "R4 sp ok");
    sp_v = 64'h1000_0078;
    do_op(mk(1, 0, 5'd2, 5'd31, 5'd1), 0, "R4 sp mis");
    do_op(mk(1, 0, 5'd2, 5'd31, 5'd31), 0, "R4 prec");
    // R10 latency independent of data
    rdy_always = 1;
    rf[4] = 64'h0; rf[5] = 64'h0; rf[6] = 64'h20;
    do_op(mk(0, 0, 5'd5, 5'd6, 5'd4), 0, "R10 a");
    chk("R10 lat mem zero", last_lat, 3);
    rf[4] = '1; rf[5] = 64'h5A5A; mem[2] = '1;
    do_op(mk(0, 0, 5'd5, 5'd6, 5'd4), 1, "R10 b");
    chk("R10 lat mem ones", last_lat, 3);
    do_op(mk(0, 0, 5'd31, 5'd6, 5'd4), 0, "R10 c");
    chk("R10 lat reject", last_lat, 1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [4:0] t, t2, n;
      logic [31:0] w;
      rdy_always = ($urandom % 3) == 0;
      t  = ($urandom % 10 == 0) ? 5'd31 : 5'($urandom % 31);
      t2 = ($urandom % 8 == 0) ? t : (($urandom % 10 == 0) ? 5'd31 : 5'($urandom % 31));
      n  = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 31);
      sp_v = ($urandom % 4 == 0) ? r64() : {r64()} & ~64'hF;
      if (n != 31) rf[n] = r64();
      w = mk(1'($urandom), 1'($urandom), t2, n, t);
      if ($urandom % 12 == 0) w = w ^ (32'h1 << ($urandom % 32));
      do_op(w, 1'($urandom), "rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule